// File: doc/BRIEF.md
# DMA Parameter-Set Store with Link Reload

This block keeps a small array of DMA transfer descriptors ("parameter sets"). Each set is eight 32-bit words. A processor register port writes and reads any word. A second port serves the channel engine: it reads descriptor words and writes back the counts and addresses the engine has advanced. When the engine reports that a set has finished its transfer, the block looks at that set's link word. If the link names a usable set, the block copies all eight words of the named set over the finished one. The reload only refreshes the descriptor. It never starts a transfer.

Some sets can be mapped to quick channels. A quick channel names one set and one word in that set as its trigger word. A processor write to that word raises a one-cycle trigger pulse, so one register write can launch a transfer. Quick-channel sets are static: the store drops engine write-back into them and never reloads them from a link.

The reload sequencer has two states. `ST_IDLE` waits for a completion report. `ST_COPY` moves one word per cycle. Transition `T_START` goes from `ST_IDLE` to `ST_COPY` when a completion is accepted with a usable link. Transition `T_FINISH` goes from `ST_COPY` back to `ST_IDLE` after the eighth word. Every other case stays in the current state.

Top module: `pset_store`

## Requirements
- R1: After reset, every descriptor word reads 0, `reload_busy` is 0 and no trigger pulse is present.
- R2: A processor write stores `cpu_wdata` at word address `{set, word}`. The word index is the low 3 bits. From the next cycle, `cpu_rdata` returns that value combinationally for `cpu_addr`.
- R3: An engine write-back (`eng_wr`) to a word of a set that is not a quick-channel set updates that word.
- R4: When a processor write and an engine write-back target the same word in the same cycle, the processor data is kept.
- R5: Word 5 of a set is its link word, and bits 15:0 hold the link as a byte offset. If a completion is reported in `ST_IDLE` for a non-quick set whose link is usable, then:
  - `reload_busy` rises after that clock edge and stays high for exactly 8 cycles.
  - After those 8 cycles, all eight words of the finished set equal the words of set `link/32`.
  - A link is usable when it is a multiple of 32 and below `NUM_SETS*32`.
- R6: A link value of 0xFFFF is null. A completion with a null link changes no word and leaves `reload_busy` low.
- R7: A link that is not a multiple of 32, or that is at or above `NUM_SETS*32`, is treated exactly like a null link.
- R8: A link reload raises no trigger pulse. Only processor writes produce `q_trig`.
- R9: Quick channel i is mapped by `q_en[i]`, `q_set[i]` and `q_word[i]`. A processor write to word `q_word[i]` of set `q_set[i]` sets `q_trig[i]` high for exactly the following cycle. A write to any other word does not raise it.
- R10: A set mapped to an enabled quick channel is static. Engine write-back into it is ignored, and a completion on it performs no reload.
- R11: A completion reported while `reload_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | AW | Processor word address `{set, word}` |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data (combinational) |
| eng_wr | input | 1 | Engine write-back strobe |
| eng_addr | input | AW | Engine word address for read and write-back |
| eng_wdata | input | 32 | Engine write-back data |
| eng_rdata | output | 32 | Engine read data (combinational) |
| done_vld | input | 1 | Transfer-complete report |
| done_set | input | SW | Set whose transfer completed |
| reload_busy | output | 1 | Link copy in progress |
| q_en | input | NUM_QCH | Quick-channel enables |
| q_set | input | NUM_QCH*SW | Set mapped to each quick channel |
| q_word | input | NUM_QCH*3 | Trigger word index for each quick channel |
| q_trig | output | NUM_QCH | One-cycle quick-channel trigger pulses |

## Verification
The bench uses the default of eight sets and two quick channels. The quick channels map to sets 6 and 7, with trigger words 1 and 2. With eight sets, link offsets at and just above the 256-byte limit can be hit, as well as misaligned offsets and the null code, alongside the valid links. Self-links and links into and out of the static quick sets also come up. With two quick channels, the bench can check that a write to one trigger word pulses only its own channel, while neighbouring words of the same set stay silent.

// File: rtl/pset_pkg.sv
package pset_pkg;
    localparam int WORD_SEL_W = 3;
    localparam int SET_WORDS  = 1 << WORD_SEL_W;
    localparam int SET_BYTES  = SET_WORDS * 4;
    localparam int OFS_BITS   = $clog2(SET_BYTES);
    localparam logic [WORD_SEL_W-1:0] WORD_LINK = 3'd5;
    localparam logic [15:0] LINK_NULL = 16'hFFFF;

    typedef enum logic {
        ST_IDLE,
        ST_COPY
    } reload_state_e;
endpackage

// File: rtl/pset_mem.sv
module pset_mem #(
    parameter int NUM_SETS = 8,
    parameter int DW       = 32,
    localparam int WORDS   = NUM_SETS * pset_pkg::SET_WORDS,
    localparam int AW      = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [DW-1:0] eng_wdata,
    output logic [DW-1:0] eng_rdata,
    input  logic          cp_we,
    input  logic [AW-1:0] cp_src,
    input  logic [AW-1:0] cp_dst,
    input  logic [AW-1:0] lk_addr,
    output logic [DW-1:0] lk_rdata
);
    logic [DW-1:0] words [WORDS];
    logic [DW-1:0] cp_data;

    assign cp_data = words[cp_src];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (cpu_we && cpu_addr == AW'(g))
                q <= cpu_wdata;
            else if (eng_we && eng_addr == AW'(g))
                q <= eng_wdata;
            else if (cp_we && cp_dst == AW'(g))
                q <= cp_data;
        end
        assign words[g] = q;
    end

    assign cpu_rdata = words[cpu_addr];
    assign eng_rdata = words[eng_addr];
    assign lk_rdata  = words[lk_addr];

    AST_CPU_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> words[$past(cpu_addr)] == $past(cpu_wdata)); // R2
    AST_CPU_BEATS_ENG: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we && eng_we && cpu_addr == eng_addr
        |=> words[$past(eng_addr)] == $past(cpu_wdata)); // R4
endmodule

// File: rtl/pset_qtrig.sv
module pset_qtrig #(
    parameter int NUM_SETS = 8,
    parameter int NUM_QCH  = 2,
    localparam int SW      = $clog2(NUM_SETS),
    localparam int WS      = pset_pkg::WORD_SEL_W,
    localparam int AW      = SW + WS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_we,
    input  logic [AW-1:0]         cpu_addr,
    input  logic [NUM_QCH-1:0]    q_en,
    input  logic [NUM_QCH*SW-1:0] q_set,
    input  logic [NUM_QCH*WS-1:0] q_word,
    input  logic [SW-1:0]         eng_set,
    input  logic [SW-1:0]         done_set,
    output logic                  eng_is_quick,
    output logic                  done_is_quick,
    output logic [NUM_QCH-1:0]    q_trig
);
    logic [NUM_QCH-1:0] hit, eng_m, done_m;

    for (genvar i = 0; i < NUM_QCH; i++) begin : g_qch
        logic [SW-1:0] qs;
        logic [WS-1:0] qw;
        assign qs = q_set[i*SW +: SW];
        assign qw = q_word[i*WS +: WS];
        assign hit[i]    = q_en[i] && cpu_we && cpu_addr == {qs, qw};
        assign eng_m[i]  = q_en[i] && eng_set == qs;
        assign done_m[i] = q_en[i] && done_set == qs;
    end

    assign eng_is_quick  = |eng_m;
    assign done_is_quick = |done_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_trig <= '0;
        else        q_trig <= hit;
    end

    AST_TRIG_FROM_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (|q_trig) |-> $past(cpu_we)); // R9
endmodule

// File: rtl/pset_link_fsm.sv
module pset_link_fsm
    import pset_pkg::*;
#(
    parameter int NUM_SETS = 8,
    localparam int SW      = $clog2(NUM_SETS),
    localparam int AW      = SW + WORD_SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_vld,
    input  logic [SW-1:0] done_set,
    input  logic          done_is_quick,
    input  logic [15:0]   link_val,
    output logic          busy,
    output logic          cp_we,
    output logic [AW-1:0] cp_src,
    output logic [AW-1:0] cp_dst
);
    reload_state_e state_q, state_d;
    logic [SW-1:0]         src_q, dst_q;
    logic [WORD_SEL_W-1:0] idx_q;
    logic                  link_ok, start;
    logic [15:0]           link_set;

    assign link_set = link_val >> OFS_BITS;
    assign link_ok  = link_val != LINK_NULL
                   && link_val[OFS_BITS-1:0] == '0
                   && link_set < 16'(NUM_SETS);
    assign start    = done_vld && link_ok && !done_is_quick;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_COPY;                      // T_START
            ST_COPY: if (idx_q == WORD_SEL_W'(SET_WORDS - 1)) state_d = ST_IDLE; // T_FINISH
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                src_q <= link_set[SW-1:0];
                dst_q <= done_set;
                idx_q <= '0;
            end else if (state_q == ST_COPY) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy   = 1'b0;
        cp_we  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_COPY: begin
                busy  = 1'b1;
                cp_we = 1'b1;
            end
        endcase
        cp_src = {src_q, idx_q};
        cp_dst = {dst_q, idx_q};
    end

    AST_NULL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && done_vld && link_val == LINK_NULL |=> state_q == ST_IDLE); // R6
    AST_BUSY_IGNORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COPY |=> $stable(dst_q) && $stable(src_q)); // R11
    AST_START_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(done_vld)); // R5
endmodule

// File: rtl/pset_store.sv
module pset_store
    import pset_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int NUM_QCH  = 2,
    localparam int SW      = $clog2(NUM_SETS),
    localparam int AW      = SW + WORD_SEL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_wr,
    input  logic [AW-1:0]                 cpu_addr,
    input  logic [31:0]                   cpu_wdata,
    output logic [31:0]                   cpu_rdata,
    input  logic                          eng_wr,
    input  logic [AW-1:0]                 eng_addr,
    input  logic [31:0]                   eng_wdata,
    output logic [31:0]                   eng_rdata,
    input  logic                          done_vld,
    input  logic [SW-1:0]                 done_set,
    output logic                          reload_busy,
    input  logic [NUM_QCH-1:0]            q_en,
    input  logic [NUM_QCH*SW-1:0]         q_set,
    input  logic [NUM_QCH*WORD_SEL_W-1:0] q_word,
    output logic [NUM_QCH-1:0]            q_trig
);
    logic          eng_is_quick, done_is_quick, eng_we, cp_we, done_take;
    logic [AW-1:0] cp_src, cp_dst;
    logic [31:0]   lk_rdata;

    assign eng_we    = eng_wr && !eng_is_quick;
    assign done_take = done_vld && !reload_busy;

    pset_qtrig #(.NUM_SETS(NUM_SETS), .NUM_QCH(NUM_QCH)) u_qtrig (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_wr), .cpu_addr(cpu_addr),
        .q_en(q_en), .q_set(q_set), .q_word(q_word),
        .eng_set(eng_addr[AW-1:WORD_SEL_W]), .done_set(done_set),
        .eng_is_quick(eng_is_quick), .done_is_quick(done_is_quick), .q_trig(q_trig)
    );

    pset_link_fsm #(.NUM_SETS(NUM_SETS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .done_vld(done_take), .done_set(done_set),
        .done_is_quick(done_is_quick), .link_val(lk_rdata[15:0]),
        .busy(reload_busy), .cp_we(cp_we), .cp_src(cp_src), .cp_dst(cp_dst)
    );

    pset_mem #(.NUM_SETS(NUM_SETS), .DW(32)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
        .cp_we(cp_we), .cp_src(cp_src), .cp_dst(cp_dst),
        .lk_addr({done_set, WORD_LINK}), .lk_rdata(lk_rdata)
    );

    AST_RELOAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        reload_busy && !cpu_wr |=> q_trig == '0); // R8
    AST_QUICK_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld && !reload_busy && done_is_quick |=> !reload_busy); // R10
endmodule

// File: tb/tb_pset_store.sv
`timescale 1ns/1ps
module tb_pset_store;
    localparam int NS = 8;
    localparam int NQ = 2;
    localparam int SW = 3;
    localparam int AW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_wr = 0, eng_wr = 0, done_vld = 0;
    logic [AW-1:0] cpu_addr = '0, eng_addr = '0;
    logic [31:0] cpu_wdata = '0, eng_wdata = '0, cpu_rdata, eng_rdata;
    logic [SW-1:0] done_set = '0;
    logic reload_busy;
    logic [NQ-1:0] q_en = 2'b11, q_trig;
    logic [NQ*SW-1:0] q_set = {3'd7, 3'd6};
    logic [NQ*3-1:0] q_word = {3'd2, 3'd1};

    int checks = 0, errors = 0;
    logic [31:0] model [64];

    always #2.5 clk = ~clk;

    pset_store #(.NUM_SETS(NS), .NUM_QCH(NQ)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .eng_wr(eng_wr),
        .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
        .done_vld(done_vld), .done_set(done_set), .reload_busy(reload_busy),
        .q_en(q_en), .q_set(q_set), .q_word(q_word), .q_trig(q_trig)
    );

    function automatic logic is_quick(logic [SW-1:0] s);
        return s == 3'd6 || s == 3'd7;
    endfunction

    function automatic logic [NQ-1:0] exp_trig(logic [AW-1:0] a);
        return {a == {3'd7, 3'd2}, a == {3'd6, 3'd1}};
    endfunction

    function automatic logic link_usable(logic [15:0] l);
        return l != 16'hFFFF && l[4:0] == 5'd0 && l < 16'(NS * 32);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_wr = 0;
        model[a] = d;
        chk("R9 trigger", 32'(q_trig), 32'(exp_trig(a)));
    endtask

    task automatic read_chk(string req, logic [AW-1:0] a);
        @(negedge clk);
        cpu_addr = a; #1;
        chk(req, cpu_rdata, model[a]);
    endtask

    task automatic eng_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        eng_wr = 1; eng_addr = a; eng_wdata = d;
        @(posedge clk); #1;
        eng_wr = 0;
        if (!is_quick(a[5:3])) model[a] = d;
        read_chk(is_quick(a[5:3]) ? "R10 static" : "R3 writeback", a);
    endtask

    task automatic do_done(logic [SW-1:0] s);
        logic [15:0] l;
        logic go;
        l  = model[{s, 3'd5}][15:0];
        go = link_usable(l) && !is_quick(s);
        @(negedge clk);
        done_vld = 1; done_set = s;
        @(posedge clk); #1;
        done_vld = 0;
        chk(go ? "R5 busy rise" : "R6 R7 null no busy", 32'(reload_busy), 32'(go));
        if (go) begin
            repeat (7) @(posedge clk);
            #1 chk("R5 busy hold", 32'(reload_busy), 1);
            @(posedge clk); #1;
            chk("R5 busy end", 32'(reload_busy), 0);
            for (int w = 0; w < 8; w++) model[{s, 3'(w)}] = model[{l[7:5], 3'(w)}];
        end
        for (int w = 0; w < 8; w++) read_chk("R5 R6 R7 contents", {s, 3'(w)});
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1 busy", 32'(reload_busy), 0);
        chk("R1 trig", 32'(q_trig), 0);
        for (int i = 0; i < 64; i += 9) read_chk("R1 zero", 6'(i));

        // R2 basic write/read
        cpu_write(6'd10, 32'hCAFE_0001);
        read_chk("R2 readback", 6'd10);
        // R9 neighbours of trigger word: only own channel
        cpu_write({3'd6, 3'd0}, 32'h11);
        cpu_write({3'd6, 3'd1}, 32'h22);
        cpu_write({3'd7, 3'd2}, 32'h33);
        cpu_write({3'd7, 3'd1}, 32'h44);
        // R10 static quick set
        eng_write({3'd6, 3'd2}, 32'hDEAD_BEEF);
        eng_write({3'd1, 3'd2}, 32'h0003_0004);
        // R4 collision
        @(negedge clk);
        cpu_wr = 1; eng_wr = 1; cpu_addr = 6'd12; eng_addr = 6'd12;
        cpu_wdata = 32'hAAAA_5555; eng_wdata = 32'h1234_5678;
        @(posedge clk); #1;
        cpu_wr = 0; eng_wr = 0;
        model[12] = 32'hAAAA_5555;
        read_chk("R4 cpu wins", 6'd12);

        // R5 valid link set 2 -> set 3, R8 no trigger during reload
        for (int w = 0; w < 8; w++) if (w != 5) cpu_write({3'd3, 3'(w)}, 32'h300 + w);
        cpu_write({3'd3, 3'd5}, 32'h0005_FFFF);
        cpu_write({3'd2, 3'd5}, 32'h0002_0060);
        do_done(3'd2);
        chk("R8 no trig after reload", 32'(q_trig), 0);
        // R6 null, R7 misaligned / out of range
        cpu_write({3'd1, 3'd5}, 32'h0000_FFFF); do_done(3'd1);
        cpu_write({3'd1, 3'd5}, 32'h0000_0044); do_done(3'd1);
        cpu_write({3'd1, 3'd5}, 32'h0000_0100); do_done(3'd1);
        // R10 completion on quick set with valid link
        cpu_write({3'd6, 3'd5}, 32'h0000_0020); do_done(3'd6);
        // R11 done while busy ignored
        cpu_write({3'd0, 3'd5}, 32'h0000_0080);
        cpu_write({3'd5, 3'd5}, 32'h0000_0040);
        @(negedge clk); done_vld = 1; done_set = 3'd0;
        @(negedge clk); done_set = 3'd5;
        @(negedge clk); done_vld = 0;
        repeat (8) @(posedge clk);
        #1 chk("R11 busy drop", 32'(reload_busy), 0);
        for (int w = 0; w < 8; w++) model[{3'd0, 3'(w)}] = model[{3'd4, 3'(w)}];
        for (int w = 0; w < 8; w++) read_chk("R11 set5 unchanged", {3'd5, 3'(w)});
        for (int w = 0; w < 8; w++) read_chk("R5 set0 reloaded", {3'd0, 3'(w)});

        // constrained random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom % 5;
            case (op)
                0: cpu_write(6'($urandom), $urandom);
                1: eng_write(6'($urandom), $urandom);
                2: read_chk("R2 random read", 6'($urandom));
                default: begin
                    logic [SW-1:0] s;
                    logic [15:0] l;
                    int kind;
                    s = 3'($urandom);
                    kind = $urandom % 4;
                    case (kind)
                        0: l = {8'd0, 3'($urandom), 5'd0};
                        1: l = 16'hFFFF;
                        2: l = {8'd0, 3'($urandom), 5'd1 + 5'($urandom % 31)};
                        default: l = 16'(NS * 32 + 32 * ($urandom % 4));
                    endcase
                    cpu_write({s, 3'd5}, {16'($urandom), l});
                    do_done(s);
                end
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule